// File: doc/BRIEF.md
# Systolic Cascaded FIR Filter

This block is a fully parallel finite impulse response filter with a fixed set of taps. It is built as a chain of identical multiply-add stages. Each stage multiplies a delayed copy of the input stream by its own constant coefficient. It adds that product to the running sum handed on by the stage before it, and registers the result for the stage after it. A delay line with two registers per tap feeds the samples, so each sample reaches every stage in the same cycle as the partial sum it belongs to. No adder tree is needed. The critical path stays at one multiply and one add however many taps the filter has.

The filter takes one sample on every clock cycle. It runs freely, and a cycle whose valid strobe is low feeds a zero sample into the stream. The valid strobe travels through a pipeline of its own and marks the output cycle that belongs to each accepted sample. Coefficients are fixed at elaboration through a packed parameter. The output is the full-precision signed sum, with no rounding and no saturation.

Top module: `systolic_fir`

## Requirements
- R1: A new sample is taken on every rising edge. On an edge where `inValid` is low, a zero sample enters the filter in place of `inData`, and the output keeps following the convolution of that zero-filled stream.
- R2: The value of `outData` visible after rising edge e equals the sum over j = 0..TAPS-1 of C[j] times the sample captured at edge e-TAPS-1-j. A sample captured at edge t therefore first shows after edge t+TAPS+1, and this latency is the same for every tap.
- R3: `outValid` is high after edge t+TAPS+1 exactly when `inValid` was high at edge t.
- R4: `outData` is a signed two's-complement sum, ACC_W bits wide, formed from DATA_W by COEF_W signed products with no rounding or saturation. This holds for the most negative sample times the most negative coefficient.
- R5: A synchronous reset clears the whole pipeline. After any rising edge with `rst` high, `outData` is zero and `outValid` is low.
- R6: Once 2*TAPS+1 consecutive edges have `inValid` low, or the same number of edges have passed since reset, `outData` is zero.
- R7: A single sample of value 1, followed by idle cycles, gives the coefficients C[0], C[1], … C[TAPS-1] on consecutive cycles, starting TAPS+1 cycles after the sample.
- R8: Coefficient C[k] is taken from bits [k*COEF_W +: COEF_W] of the `COEFS` parameter as a signed value. Taps with k at or above TAPS are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Marks `inData` as a real sample; when low, a zero sample is used |
| inData | input | DATA_W | Signed input sample |
| outValid | output | 1 | High on the output cycle that belongs to a valid input sample |
| outData | output | ACC_W | Signed full-precision filter output |

## Verification
The bound checker checks four things on every cycle: the alignment of the valid strobe against the input strobe, the cleared output after reset, the zero output once the pipeline has drained, and the absence of unknown output bits. The actual arithmetic can only be shown by the bench's scenarios. These are a unit impulse that reads back the coefficient order, streams of back-to-back random samples, streams with random gaps, runs at the extremes of the number range, and a reset asserted in mid-stream. In each scenario every output cycle is compared with a convolution computed in the bench.

// File: rtl/sysfir_pkg.sv
package sysfir_pkg;

  localparam int DEF_TAPS   = 32;
  localparam int DEF_DATA_W = 18;
  localparam int DEF_COEF_W = 18;
  localparam int DEF_ACC_W  = 48;
  localparam int MAX_TAPS   = 64;

  // Strobes from the control section to the datapath.
  typedef struct packed {
    logic takeSample;   // present input is a real sample
    logic clearPipe;    // synchronous clear of all data registers
  } firCtrlT;

  // Default coefficient set: a small integer ramp pattern, scaled.
  function automatic logic [MAX_TAPS*DEF_COEF_W-1:0] defaultCoefs();
    logic [MAX_TAPS*DEF_COEF_W-1:0] packedSet;
    packedSet = '0;
    for (int k = 0; k < MAX_TAPS; k++) begin
      logic signed [31:0] val;
      val = (((k * 5) + 3) % 23 - 11) * 1000;
      packedSet[k*DEF_COEF_W +: DEF_COEF_W] = val[DEF_COEF_W-1:0];
    end
    return packedSet;
  endfunction

endpackage

// File: rtl/sysfir_ctrl.sv
module sysfir_ctrl
  import sysfir_pkg::*;
#(
  parameter int TAPS = DEF_TAPS
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  output firCtrlT ctrl,
  output logic    outValid
);

  // The data path needs TAPS+1 edges after the capture edge; the capture
  // edge itself is the first stage of this strobe pipeline.
  localparam int VLD_DEPTH = TAPS + 2;

  logic [VLD_DEPTH-1:0] vldPipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      vldPipe <= '0;
    end else begin
      vldPipe <= {vldPipe[VLD_DEPTH-2:0], inValid};
    end
  end

  always_comb begin
    ctrl.takeSample = inValid & ~rst;
    ctrl.clearPipe  = rst;
  end

  assign outValid = vldPipe[VLD_DEPTH-1];

endmodule

// File: rtl/sysfir_delay_line.sv
module sysfir_delay_line #(
  parameter int DATA_W = 18,
  parameter int LEN    = 64
) (
  input  logic                     clk,
  input  logic                     clear,
  input  logic signed [DATA_W-1:0] din,
  output logic signed [DATA_W-1:0] taps [LEN]
);

  for (genvar i = 0; i < LEN; i++) begin : g_reg
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (clear) taps[i] <= '0;
        else       taps[i] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (clear) taps[i] <= '0;
        else       taps[i] <= taps[i-1];
      end
    end
  end

endmodule

// File: rtl/sysfir_mac_stage.sv
module sysfir_mac_stage #(
  parameter int                 DATA_W = 18,
  parameter int                 COEF_W = 18,
  parameter int                 ACC_W  = 48,
  parameter logic [COEF_W-1:0]  COEF   = '0
) (
  input  logic                     clk,
  input  logic                     clear,
  input  logic signed [DATA_W-1:0] sample,
  input  logic signed [ACC_W-1:0]  sumIn,
  output logic signed [ACC_W-1:0]  sumOut
);

  localparam int PROD_W = DATA_W + COEF_W;
  localparam int EXT_W  = ACC_W - PROD_W;

  logic signed [PROD_W-1:0] sampleExt;
  logic signed [PROD_W-1:0] coefExt;
  logic signed [PROD_W-1:0] product;
  logic signed [ACC_W-1:0]  productExt;

  always_comb begin
    sampleExt  = {{COEF_W{sample[DATA_W-1]}}, sample};
    coefExt    = {{DATA_W{COEF[COEF_W-1]}}, COEF};
    product    = sampleExt * coefExt;
    productExt = {{EXT_W{product[PROD_W-1]}}, product};
  end

  always_ff @(posedge clk) begin
    if (clear) sumOut <= '0;
    else       sumOut <= sumIn + productExt;
  end

endmodule

// File: rtl/sysfir_datapath.sv
module sysfir_datapath
  import sysfir_pkg::*;
#(
  parameter int                            TAPS   = DEF_TAPS,
  parameter int                            DATA_W = DEF_DATA_W,
  parameter int                            COEF_W = DEF_COEF_W,
  parameter int                            ACC_W  = DEF_ACC_W,
  parameter logic [MAX_TAPS*COEF_W-1:0]    COEFS  = '0
) (
  input  logic                     clk,
  input  firCtrlT                  ctrl,
  input  logic signed [DATA_W-1:0] inData,
  output logic signed [ACC_W-1:0]  outData
);

  // Two sample registers per tap: tap k reads the second one of its pair,
  // which lines the sample up with the partial sum arriving from tap k-1.
  localparam int DLY_LEN = 2 * TAPS;

  logic signed [DATA_W-1:0] gatedSample;
  logic signed [DATA_W-1:0] dly [DLY_LEN];
  logic signed [ACC_W-1:0]  cascade [TAPS];

  assign gatedSample = ctrl.takeSample ? inData : '0;

  sysfir_delay_line #(
    .DATA_W (DATA_W),
    .LEN    (DLY_LEN)
  ) u_dly (
    .clk   (clk),
    .clear (ctrl.clearPipe),
    .din   (gatedSample),
    .taps  (dly)
  );

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    localparam logic [COEF_W-1:0] TAP_COEF = COEFS[k*COEF_W +: COEF_W];
    if (k == 0) begin : g_first
      sysfir_mac_stage #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .ACC_W  (ACC_W),
        .COEF   (TAP_COEF)
      ) u_mac (
        .clk    (clk),
        .clear  (ctrl.clearPipe),
        .sample (dly[2*k+1]),
        .sumIn  ('0),
        .sumOut (cascade[k])
      );
    end else begin : g_next
      sysfir_mac_stage #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .ACC_W  (ACC_W),
        .COEF   (TAP_COEF)
      ) u_mac (
        .clk    (clk),
        .clear  (ctrl.clearPipe),
        .sample (dly[2*k+1]),
        .sumIn  (cascade[k-1]),
        .sumOut (cascade[k])
      );
    end
  end

  assign outData = cascade[TAPS-1];

endmodule

// File: rtl/systolic_fir.sv
module systolic_fir
  import sysfir_pkg::*;
#(
  parameter int                         TAPS   = DEF_TAPS,
  parameter int                         DATA_W = DEF_DATA_W,
  parameter int                         COEF_W = DEF_COEF_W,
  parameter int                         ACC_W  = DEF_ACC_W,
  parameter logic [MAX_TAPS*COEF_W-1:0] COEFS  = defaultCoefs()
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inData,
  output logic                     outValid,
  output logic signed [ACC_W-1:0]  outData
);

  firCtrlT ctrl;

  sysfir_ctrl #(
    .TAPS (TAPS)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  sysfir_datapath #(
    .TAPS   (TAPS),
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .ACC_W  (ACC_W),
    .COEFS  (COEFS)
  ) u_dp (
    .clk     (clk),
    .ctrl    (ctrl),
    .inData  (inData),
    .outData (outData)
  );

endmodule

// File: rtl/sysfir_checker.sv
module sysfir_checker #(
  parameter int TAPS  = 32,
  parameter int ACC_W = 48
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             outValid,
  input logic [ACC_W-1:0] outData
);

  localparam int VLD_DEPTH = TAPS + 2;
  localparam int IDLE_MAX  = 2 * TAPS + 1;
  localparam int CNT_W     = $clog2(IDLE_MAX + 1);

  logic [VLD_DEPTH-1:0] seenValid;
  logic [CNT_W-1:0]     idleCnt;
  logic                 rstQ;

  always_ff @(posedge clk) begin
    if (rst) seenValid <= '0;
    else     seenValid <= {seenValid[VLD_DEPTH-2:0], inValid};
  end

  always_ff @(posedge clk) begin
    if (rst)                            idleCnt <= CNT_W'(IDLE_MAX);
    else if (inValid)                   idleCnt <= '0;
    else if (idleCnt != CNT_W'(IDLE_MAX)) idleCnt <= idleCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    rstQ <= rst;
    // R5: the values left by a reset edge are cleared
    a_r5_reset_clears: assert (!rstQ || (outData == '0 && !outValid))
      else $error("a_r5_reset_clears");
  end

  // R3: the output strobe trails the input strobe by the fixed latency
  a_r3_valid_delay: assert property (@(posedge clk) disable iff (rst)
    outValid == seenValid[VLD_DEPTH-1]);

  // R6: a drained pipeline produces zero
  a_r6_drain_zero: assert property (@(posedge clk) disable iff (rst)
    (idleCnt == CNT_W'(IDLE_MAX)) |-> (outData == '0));

  // R2: the output never carries unknown bits
  a_r2_no_unknown: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(outData));

endmodule

bind systolic_fir sysfir_checker #(
  .TAPS  (TAPS),
  .ACC_W (ACC_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .outValid (outValid),
  .outData  (outData)
);

// File: tb/systolic_fir_tb.sv
`timescale 1ns/1ps
module systolic_fir_tb;

  localparam int TAPS   = 16;
  localparam int DATA_W = 18;
  localparam int COEF_W = 18;
  localparam int ACC_W  = 48;
  localparam int HIST   = 2048;

  function automatic int tbCoef(int k);
    if (k == 0)        return 131071;
    if (k == TAPS - 1) return -131072;
    return ((k * 7331 + 19) % 50001) - 25000;
  endfunction

  function automatic logic [64*COEF_W-1:0] buildCoefs();
    logic [64*COEF_W-1:0] v;
    v = '0;
    for (int k = 0; k < TAPS; k++) begin
      logic signed [31:0] c;
      c = tbCoef(k);
      v[k*COEF_W +: COEF_W] = c[COEF_W-1:0];
    end
    // R8: lanes above TAPS hold junk that must not matter
    for (int k = TAPS; k < 64; k++) v[k*COEF_W +: COEF_W] = 18'h2AAAA;
    return v;
  endfunction

  logic                     clk = 1'b0;
  logic                     rst;
  logic                     inValid;
  logic signed [DATA_W-1:0] inData;
  logic                     outValid;
  logic signed [ACC_W-1:0]  outData;

  systolic_fir #(
    .TAPS   (TAPS),
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .ACC_W  (ACC_W),
    .COEFS  (buildCoefs())
  ) u_dut (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inData   (inData),
    .outValid (outValid),
    .outData  (outData)
  );

  always #4 clk = ~clk;

  int     checks = 0;
  int     fails  = 0;
  int     n      = 0;
  bit     finished = 1'b0;
  longint xs [HIST];
  bit     vs [HIST];

  function automatic longint refAt(int e);
    longint acc = 0;
    for (int j = 0; j < TAPS; j++) begin
      int idx = e - TAPS - 1 - j;
      if (idx >= 0) acc += longint'(tbCoef(j)) * xs[idx];
    end
    return acc;
  endfunction

  task automatic checkEq(input string tag, input string what,
                         input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clearHistory();
    for (int i = 0; i < HIST; i++) begin
      xs[i] = 0;
      vs[i] = 1'b0;
    end
    n = 0;
  endtask

  // Drive one cycle, then compare the outputs left by that edge.
  task automatic step(input logic v, input logic signed [DATA_W-1:0] d,
                      input string tag);
    longint expD;
    bit     expV;
    inValid = v;
    inData  = d;
    if (n < HIST) begin
      xs[n] = v ? longint'(d) : 0;
      vs[n] = v;
    end
    @(posedge clk);
    @(negedge clk);
    expD = refAt(n);
    expV = (n - TAPS - 1 >= 0) ? vs[n - TAPS - 1] : 1'b0;
    checkEq(tag, "outData", longint'(outData), expD);
    checkEq("R3", "outValid", longint'(outValid), longint'(expV));
    n++;
  endtask

  task automatic resetFor(input int cycles);
    rst = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      inValid = 1'b1;
      inData  = DATA_W'($urandom);
      @(posedge clk);
      @(negedge clk);
      checkEq("R5", "outData after reset", longint'(outData), 0);
      checkEq("R5", "outValid after reset", longint'(outValid), 0);
    end
    rst = 1'b0;
    inValid = 1'b0;
    clearHistory();
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240);
    rst = 1'b1;
    inValid = 1'b0;
    inData = '0;
    clearHistory();
    @(negedge clk);
    resetFor(3);

    // R7 and R8: unit impulse reads back the coefficients in tap order
    step(1'b1, 18'sd1, "R7");
    for (int i = 0; i < 2 * TAPS + 2; i++) step(1'b0, '0, "R7");
    for (int k = 0; k < TAPS; k++)
      checkEq("R8", "impulse tap", refAt(TAPS + 1 + k), longint'(tbCoef(k)));

    // R6: drained pipeline reads zero
    checkEq("R6", "drained output", longint'(outData), 0);

    // R2: back-to-back random samples
    for (int i = 0; i < 200; i++) step(1'b1, DATA_W'($urandom), "R2");

    // R1: random gaps feed zeros
    for (int i = 0; i < 300; i++)
      step(($urandom % 2) == 0, DATA_W'($urandom), "R1");
    for (int i = 0; i < 2 * TAPS + 1; i++) step(1'b0, DATA_W'($urandom), "R6");
    checkEq("R6", "output after idle run", longint'(outData), 0);

    // R4: extremes of the number range
    for (int i = 0; i < 2 * TAPS + 2; i++) step(1'b1, -18'sd131072, "R4");
    for (int i = 0; i < 2 * TAPS + 2; i++) step(1'b1, 18'sd131071, "R4");
    for (int i = 0; i < 2 * TAPS; i++)
      step(1'b1, (i % 2 == 0) ? -18'sd131072 : 18'sd131071, "R4");
    for (int i = 0; i < 2 * TAPS + 2; i++) step(1'b0, '0, "R4");

    // R5: reset in mid-stream, then filtering restarts cleanly
    for (int i = 0; i < 20; i++) step(1'b1, DATA_W'($urandom), "R2");
    resetFor(2);
    for (int i = 0; i < 100; i++)
      step(($urandom % 4) != 0, DATA_W'($urandom), "R2");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule